// File: doc/BRIEF.md
# Rank Power-Down Controller

This block runs next to a DDR3-style command scheduler and owns the clock-enable (CKE) level of every rank on one memory channel. Each rank has its own idle counter. When a rank has been idle long enough, the block lowers that rank's CKE and puts it into one of three power-down flavours. A new request for the rank raises CKE again. The block then holds back commands, and also data transfers, until that flavour's exit delay has run out.

A channel-wide self-refresh request moves every rank into self-refresh together. While the request is held, the block ignores rank requests. Once released, every rank exits along the long (DLL-relock) data path. The block also gives each rank a qualifier for its input termination. A shared cadence gate enforces 1n or 2n command spacing, so the scheduler can AND the command-allowed and data-allowed outputs straight into its own issue logic.

Top module: `rank_pwrdn_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, every CKE, command-allowed, data-allowed and termination-enable output is high and the self-refresh flag is low.
- R2: A cycle is idle for a rank when neither its request nor its command input is high. If the idle threshold is L, CKE for that rank goes low at the clock edge that samples the (L+1)-th consecutive idle cycle. Any request or command to the rank restarts the count.
- R3: A request to a rank in power-down raises its CKE at the next clock edge. Command-allowed then stays low for E further cycles, where E is the exit-latency field clamped to the range 3 to 5.
- R4: The flavour is latched when power-down is entered. Code 0 is active power-down, the value tied off by default. Code 1 is fast-exit precharge power-down, code 2 is slow-exit precharge power-down, and code 3 behaves as code 0. For codes 0, 1 and 3, data-allowed rises with command-allowed. For code 2, data-allowed rises max(E, D) cycles after CKE rises, where D is the data-latency field (nominally 16).
- R5: A request seen in the first cycle of power-down entry aborts the entry. CKE rises at the next edge and the normal exit delay of R3 follows.
- R6: While a rank's CKE is low, its command-allowed and data-allowed outputs are low.
- R7: A high self-refresh request drives every CKE low at the next edge, and rank requests have no effect while it is held. The self-refresh flag is high while all ranks are in self-refresh. On release, CKE rises at the next edge, with command delay E and data delay max(E, D).
- R8: With 2n cadence selected, a command to any rank makes command-allowed low for all ranks in the following cycle. With 1n cadence there is no such gap.
- R9: A rank's termination enable is low exactly when its CKE is low and the termination-off option is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rank_req | input | NRANK | Request pending for each rank |
| rank_cmd | input | NRANK | Command issued to each rank this cycle |
| cfg_idle_limit | input | IDLE_W | Idle threshold L |
| cfg_pd_mode | input | 2 | Power-down flavour code |
| cfg_exit_lat | input | 3 | Exit latency to first command (clamped 3..5) |
| cfg_data_lat | input | LAT_W | Slow-exit latency to first data |
| cfg_term_off | input | 1 | Turn termination off while CKE is low |
| cfg_cmd_2n | input | 1 | Select 2n command cadence |
| sref_req | input | 1 | Channel-wide self-refresh request |
| cke | output | NRANK | Clock enable per rank |
| cmd_ok | output | NRANK | Command may issue to the rank |
| data_ok | output | NRANK | Data transfer may start on the rank |
| term_en | output | NRANK | Input termination enable per rank |
| sref_active | output | 1 | All ranks are in self-refresh |

## Verification
Four properties are checked on every cycle: no qualifier is high while CKE is low, command-allowed stays low on the first cycle after CKE rises, self-refresh pulls every CKE low and holds the flag only while all are low, and the 2n gap follows every command. Only the bench scenarios can show the exact idle count before entry, the clamped exit latencies, the per-flavour data delay, the abort of an entry, and request immunity during self-refresh, because each of these depends on a counted span of cycles.

// File: rtl/rpd_pkg.sv
// Shared types for the rank power-down controller.
// Assumes the flavour codes are fixed by the scheduler's configuration map.
package rpd_pkg;
    typedef enum logic [1:0] {
        PD_ACTIVE = 2'd0,
        PD_FAST   = 2'd1,
        PD_SLOW   = 2'd2,
        PD_ALT    = 2'd3
    } pd_mode_e;

    typedef enum logic [2:0] {
        ST_UP    = 3'd0,
        ST_ENTER = 3'd1,
        ST_PD    = 3'd2,
        ST_EXIT  = 3'd3,
        ST_SR    = 3'd4
    } rank_st_e;

    localparam logic [2:0] EXIT_MIN = 3'd3;
    localparam logic [2:0] EXIT_MAX = 3'd5;

    // Restricts the command exit latency to the legal window.
    function automatic logic [2:0] clamp_exit(input logic [2:0] raw);
        if (raw < EXIT_MIN) return EXIT_MIN;
        if (raw > EXIT_MAX) return EXIT_MAX;
        return raw;
    endfunction
endpackage

// File: rtl/rpd_cadence.sv
// Command cadence gate: in 2n mode, blanks the command slot for one
// cycle after any command on the channel. Assumes rank_cmd is only
// asserted when the scheduler saw the slot open.
module rpd_cadence #(
    parameter int NRANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cmd_2n,
    input  logic [NRANK-1:0] rank_cmd,
    output logic             slot_open
);
    logic gap_q;

    // Remembers whether the previous cycle used a slot under 2n cadence.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= cfg_cmd_2n && (|rank_cmd);
    end

    assign slot_open = !gap_q;
endmodule

// File: rtl/rpd_rank.sv
// Per-rank power state machine: idle counting, entry, exit timing and
// self-refresh residency. Assumes exit_lat is already clamped to 3..5.
module rpd_rank
    import rpd_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int LAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              cmd,
    input  logic              sref_req,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [1:0]        pd_mode,
    input  logic [2:0]        exit_lat,
    input  logic [LAT_W-1:0]  data_lat,
    output logic              cke,
    output logic              cmd_rdy,
    output logic              data_rdy,
    output logic              in_sr
);
    localparam logic [IDLE_W-1:0] IDLE_SAT = '1;
    localparam logic [LAT_W-1:0]  ECNT_SAT = '1;

    rank_st_e          st_q;
    logic [IDLE_W-1:0] idle_q;
    logic [LAT_W-1:0]  ecnt_q;
    logic              slow_q;
    logic [LAT_W-1:0]  elat_w;
    logic [LAT_W-1:0]  need_w;
    logic              exit_done;

    // Widens the command latency and picks the data latency for this exit.
    always_comb begin
        elat_w = LAT_W'(exit_lat);
        need_w = elat_w;
        if (slow_q && (data_lat > elat_w)) need_w = data_lat;
    end

    assign exit_done = (ecnt_q >= need_w);

    // Advances the power state, idle counter and exit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_UP;
            idle_q <= '0;
            ecnt_q <= '0;
            slow_q <= 1'b0;
        end else if (sref_req) begin
            st_q   <= ST_SR;
            idle_q <= '0;
            ecnt_q <= '0;
            slow_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_UP: begin
                    if (req || cmd) begin
                        idle_q <= '0;
                    end else if (idle_q >= idle_limit) begin
                        st_q   <= ST_ENTER;
                        idle_q <= '0;
                        slow_q <= (pd_mode == PD_SLOW);
                    end else if (idle_q != IDLE_SAT) begin
                        idle_q <= idle_q + 1'b1;
                    end
                end
                ST_ENTER: begin
                    ecnt_q <= '0;
                    st_q   <= req ? ST_EXIT : ST_PD;
                end
                ST_PD: begin
                    ecnt_q <= '0;
                    if (req) st_q <= ST_EXIT;
                end
                ST_EXIT: begin
                    if (exit_done)               st_q   <= ST_UP;
                    else if (ecnt_q != ECNT_SAT) ecnt_q <= ecnt_q + 1'b1;
                end
                ST_SR: begin
                    ecnt_q <= '0;
                    st_q   <= ST_EXIT;
                end
                default: st_q <= ST_UP;
            endcase
        end
    end

    // Decodes the rank outputs from the registered state.
    always_comb begin
        cke      = (st_q == ST_UP) || (st_q == ST_EXIT);
        cmd_rdy  = (st_q == ST_UP) || ((st_q == ST_EXIT) && (ecnt_q >= elat_w));
        data_rdy = (st_q == ST_UP) || ((st_q == ST_EXIT) && exit_done);
        in_sr    = (st_q == ST_SR);
    end
endmodule

// File: rtl/rank_pwrdn_ctrl.sv
// Top of the rank power-down controller: one state machine per rank,
// a shared cadence gate and the termination qualifiers.
// Assumes all configuration inputs are quasi-static between exits.
module rank_pwrdn_ctrl
    import rpd_pkg::*;
#(
    parameter int NRANK  = 2,
    parameter int IDLE_W = 8,
    parameter int LAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRANK-1:0]  rank_req,
    input  logic [NRANK-1:0]  rank_cmd,
    input  logic [IDLE_W-1:0] cfg_idle_limit,
    input  logic [1:0]        cfg_pd_mode,
    input  logic [2:0]        cfg_exit_lat,
    input  logic [LAT_W-1:0]  cfg_data_lat,
    input  logic              cfg_term_off,
    input  logic              cfg_cmd_2n,
    input  logic              sref_req,
    output logic [NRANK-1:0]  cke,
    output logic [NRANK-1:0]  cmd_ok,
    output logic [NRANK-1:0]  data_ok,
    output logic [NRANK-1:0]  term_en,
    output logic              sref_active
);
    logic [2:0]       exit_lat_c;
    logic [NRANK-1:0] rank_cmd_rdy;
    logic [NRANK-1:0] rank_in_sr;
    logic             slot_open;

    assign exit_lat_c = clamp_exit(cfg_exit_lat);

    rpd_cadence #(.NRANK(NRANK)) u_cadence (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cmd_2n (cfg_cmd_2n),
        .rank_cmd   (rank_cmd),
        .slot_open  (slot_open)
    );

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        rpd_rank #(.IDLE_W(IDLE_W), .LAT_W(LAT_W)) u_rank (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (rank_req[r]),
            .cmd        (rank_cmd[r]),
            .sref_req   (sref_req),
            .idle_limit (cfg_idle_limit),
            .pd_mode    (cfg_pd_mode),
            .exit_lat   (exit_lat_c),
            .data_lat   (cfg_data_lat),
            .cke        (cke[r]),
            .cmd_rdy    (rank_cmd_rdy[r]),
            .data_rdy   (data_ok[r]),
            .in_sr      (rank_in_sr[r])
        );
    end

    // Combines rank readiness with the cadence slot and termination option.
    always_comb begin
        cmd_ok      = rank_cmd_rdy & {NRANK{slot_open}};
        term_en     = cke | {NRANK{!cfg_term_off}};
        sref_active = &rank_in_sr;
    end
endmodule

// File: rtl/rpd_chk.sv
// Cycle-level properties of the rank power-down controller, attached
// to every instance of the top by the bind below.
module rpd_chk #(
    parameter int NRANK = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NRANK-1:0] rank_cmd,
    input logic             cfg_cmd_2n,
    input logic             sref_req,
    input logic [NRANK-1:0] cke,
    input logic [NRANK-1:0] cmd_ok,
    input logic [NRANK-1:0] data_ok,
    input logic             sref_active
);
    // R6
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cke) & (cmd_ok | data_ok)) == '0);

    // R3
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cke & ~$past(cke) & cmd_ok) == '0));

    // R7
    sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sref_req |=> (cke == '0));

    // R7
    sref_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sref_active |-> (cke == '0));

    // R8
    cadence_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmd_2n && (|rank_cmd)) |=> (cmd_ok == '0));
endmodule

bind rank_pwrdn_ctrl rpd_chk #(.NRANK(NRANK)) u_rpd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rank_cmd    (rank_cmd),
    .cfg_cmd_2n  (cfg_cmd_2n),
    .sref_req    (sref_req),
    .cke         (cke),
    .cmd_ok      (cmd_ok),
    .data_ok     (data_ok),
    .sref_active (sref_active)
);

// File: tb/sim_rank_pwrdn_ctrl.sv
`timescale 1ns/1ps
module sim_rank_pwrdn_ctrl;
    localparam int NRANK  = 2;
    localparam int IDLE_W = 8;
    localparam int LAT_W  = 5;
    localparam int NVEC   = 7;
    localparam int CAP    = 100;

    // columns: mode, idle limit, exit field, data field,
    //          expected idle edges, expected cmd delay, expected data delay
    localparam int VEC [NVEC][7] = '{
        '{0, 4, 3, 16, 5, 3, 3},
        '{1, 0, 5, 16, 1, 5, 5},
        '{2, 7, 4, 16, 8, 4, 16},
        '{2, 2, 7, 10, 3, 5, 10},
        '{0, 3, 1, 16, 4, 3, 3},
        '{2, 1, 5, 2,  2, 5, 5},
        '{3, 1, 4, 16, 2, 4, 4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NRANK-1:0]  rank_req = '0;
    logic [NRANK-1:0]  rank_cmd = '0;
    logic [IDLE_W-1:0] cfg_idle_limit = 8'd4;
    logic [1:0]        cfg_pd_mode = 2'd0;
    logic [2:0]        cfg_exit_lat = 3'd3;
    logic [LAT_W-1:0]  cfg_data_lat = 5'd16;
    logic              cfg_term_off = 1'b0;
    logic              cfg_cmd_2n = 1'b0;
    logic              sref_req = 1'b0;
    logic [NRANK-1:0]  cke, cmd_ok, data_ok, term_en;
    logic              sref_active;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rank_pwrdn_ctrl #(.NRANK(NRANK), .IDLE_W(IDLE_W), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rank_req(rank_req), .rank_cmd(rank_cmd),
        .cfg_idle_limit(cfg_idle_limit), .cfg_pd_mode(cfg_pd_mode),
        .cfg_exit_lat(cfg_exit_lat), .cfg_data_lat(cfg_data_lat),
        .cfg_term_off(cfg_term_off), .cfg_cmd_2n(cfg_cmd_2n),
        .sref_req(sref_req), .cke(cke), .cmd_ok(cmd_ok), .data_ok(data_ok),
        .term_en(term_en), .sref_active(sref_active)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Edges until cke[r] equals val, at least one edge.
    task automatic wait_cke(input int r, input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cke[r] != val && n < CAP);
    endtask

    // From the current cycle, edges until cmd_ok and data_ok of rank r rise.
    task automatic wait_ready(input int r, output int nc, output int nd);
        nc = -1;
        nd = -1;
        for (int n = 0; n < CAP; n++) begin
            if (cmd_ok[r] && nc < 0) nc = n;
            if (data_ok[r] && nd < 0) nd = n;
            if (nc >= 0 && nd >= 0) break;
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, nc, nd;
        ticks(3);
        // R1 reset state
        check("R1 cke in reset", int'(cke), 3);
        check("R1 term in reset", int'(term_en), 3);
        rank_req = 2'b11;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cke after reset", int'(cke), 3);
        check("R1 cmd_ok after reset", int'(cmd_ok), 3);
        check("R1 data_ok after reset", int'(data_ok), 3);
        check("R1 sref flag after reset", int'(sref_active), 0);

        // Table walk: entry count, exit delays per flavour (R2 R3 R4 R6)
        for (int v = 0; v < NVEC; v++) begin
            cfg_pd_mode    = 2'(VEC[v][0]);
            cfg_idle_limit = 8'(VEC[v][1]);
            cfg_exit_lat   = 3'(VEC[v][2]);
            cfg_data_lat   = 5'(VEC[v][3]);
            rank_req = 2'b11;
            @(negedge clk);
            rank_req = 2'b10;
            wait_cke(0, 1'b0, n);
            check($sformatf("R2 idle edges vec%0d", v), n, VEC[v][4]);
            ticks(2);
            check($sformatf("R6 qualifiers in pd vec%0d", v),
                  int'({cmd_ok[0], data_ok[0]}), 0);
            check($sformatf("R2 other rank stays up vec%0d", v), int'(cke[1]), 1);
            rank_req = 2'b11;
            wait_cke(0, 1'b1, n);
            check($sformatf("R3 cke rise vec%0d", v), n, 1);
            wait_ready(0, nc, nd);
            check($sformatf("R3 cmd delay vec%0d", v), nc, VEC[v][5]);
            check($sformatf("R4 data delay vec%0d", v), nd, VEC[v][6]);
            ticks(2);
        end

        // R2 command restarts idle count
        cfg_pd_mode = 2'd0; cfg_idle_limit = 8'd4; cfg_exit_lat = 3'd3;
        rank_req = 2'b10;
        ticks(3);
        rank_cmd = 2'b01;
        @(negedge clk);
        rank_cmd = 2'b00;
        check("R2 cke high after cmd", int'(cke[0]), 1);
        wait_cke(0, 1'b0, n);
        check("R2 idle edges after cmd", n, 5);

        // R9 termination off while cke low
        cfg_term_off = 1'b1;
        ticks(2);
        check("R9 term off rank0", int'(term_en[0]), 0);
        check("R9 term on rank1", int'(term_en[1]), 1);
        cfg_term_off = 1'b0;
        @(negedge clk);
        check("R9 term kept when option clear", int'(term_en[0]), 1);
        rank_req = 2'b11;
        wait_cke(0, 1'b1, n);
        ticks(6);

        // R5 request in the entry cycle aborts entry
        cfg_idle_limit = 8'd2;
        rank_req = 2'b10;
        wait_cke(0, 1'b0, n);
        rank_req = 2'b11;
        @(negedge clk);
        check("R5 cke back after abort", int'(cke[0]), 1);
        wait_ready(0, nc, nd);
        check("R5 cmd delay after abort", nc, 3);
        ticks(2);

        // R7 self-refresh entry, request immunity, release
        cfg_data_lat = 5'd16;
        sref_req = 1'b1;
        @(negedge clk);
        check("R7 all cke low", int'(cke), 0);
        check("R7 sref flag", int'(sref_active), 1);
        ticks(4);
        check("R7 requests ignored", int'(cke), 0);
        check("R7 cmd_ok low", int'(cmd_ok), 0);
        sref_req = 1'b0;
        @(negedge clk);
        check("R7 cke after release", int'(cke), 3);
        check("R7 flag cleared", int'(sref_active), 0);
        wait_ready(0, nc, nd);
        check("R7 cmd delay", nc, 3);
        check("R7 data delay", nd, 16);
        ticks(3);

        // R8 2n cadence gap, then 1n with no gap
        cfg_cmd_2n = 1'b1;
        rank_cmd = 2'b01;
        @(negedge clk);
        rank_cmd = 2'b00;
        check("R8 2n gap", int'(cmd_ok), 0);
        @(negedge clk);
        check("R8 2n slot reopens", int'(cmd_ok), 3);
        cfg_cmd_2n = 1'b0;
        rank_cmd = 2'b10;
        @(negedge clk);
        rank_cmd = 2'b00;
        check("R8 1n no gap", int'(cmd_ok), 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule